// File: doc/BRIEF.md
# Two-Coil Stepping Motor PWM Drive

This block produces the four drive signals for a two-coil stepping motor. Each coil owns an 8-bit pulse-width generator and a pair of outputs, a plus side and a minus side. A per-coil steering code decides which side of the pair carries the pulse train and which side is held. Changing the code reverses the direction of coil current, and a brake code drives both sides high.

Both generators are clocked by one shared up-counter whose count rate is chosen from four divisions of the system clock. Software writes duty and steering values into holding registers over a simple write bus. The values move into the working registers only when the counter wraps from its top value to zero. Duty and polarity changes therefore land on all four outputs at the same period boundary, and a period that has already started is never cut short. When the block is switched off, each output follows a plain port bit instead.

Top module: `stepper_pwm_drive`

## Requirements
- R1: While reset is asserted, all four coil outputs are low and the block is switched off with rate code 00.
- R2: While the enable bit is 0, each coil output equals the matching `portBits` bit, registered one clock later.
- R3: Once enabled, the shared 8-bit count starts at 0 and steps to 255 before it wraps. A pulsed output is high while the count is below the coil's duty value. The high time is one unbroken stretch at the start of each 256-count period.
- R4: A duty value of 0 gives no high time, and a value of 255 gives 255 of every 256 counts.
- R5: Steering code in bits 1:0 of a coil's select register: 00 holds both outputs low, 01 pulses the plus output with minus low, and 10 pulses the minus output with plus low. Output bit 2i is the plus side of coil i and bit 2i+1 is its minus side.
- R6: Steering code 11 drives both outputs of the coil high for the whole period.
- R7: Rate code in control bits 2:1 sets the system clocks per count: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R8: New duty and steering values written during a period take effect on both coils from the next wrap. The period in progress keeps the old values.
- R9: The plus and minus outputs of one coil are never both high unless that coil's steering code is 11.
- R10: Write addresses are 0 for control (bit 0 enable, bits 2:1 rate), 1+i for the duty of coil i and 3+i for the steering code of coil i. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| portBits | input | 4 | Fallback levels used while switched off |
| coilOut | output | 4 | Coil drive: {B minus, B plus, A minus, A plus} |

## Verification
The output register lags the count by one clock. After the enable write lands on edge E, the output for count 0 appears after edge E+1, and each later period follows without a gap every 256×d clocks, where d is the selected division. The scoreboard therefore samples on falling edges in windows of exactly 256×d samples, starting at the first falling edge after E+1. It tallies the high time, the unbroken start stretch and the coincident highs for each window against a queued expected item. Values written in the middle of a window are expected in the next window. Port fallback is due one clock after the pins change.

// File: rtl/stepper_pwm_pkg.sv
package stepper_pwm_pkg;

  typedef enum logic [1:0] {
    SEL_OFF   = 2'b00,
    SEL_PLUS  = 2'b01,
    SEL_MINUS = 2'b10,
    SEL_BRAKE = 2'b11
  } coilSel_e;

  typedef struct packed {
    logic run;
    logic tick;
  } pwmStrobe_t;

endpackage

// File: rtl/stepper_pwm_ctrl.sv
module stepper_pwm_ctrl
  import stepper_pwm_pkg::*;
#(
  parameter int COILS     = 2,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int RATE0_DIV = 1,
  parameter int RATE1_DIV = 2,
  parameter int RATE2_DIV = 4,
  parameter int RATE3_DIV = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  output pwmStrobe_t                    strobe,
  output logic [COILS-1:0][CNT_W-1:0]   cmpShadow,
  output logic [COILS-1:0][1:0]         selShadow
);

  localparam int MAX_DIV = (RATE3_DIV > RATE2_DIV) ? RATE3_DIV : RATE2_DIV;
  localparam int PRE_W   = $clog2(MAX_DIV + 1);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic             runQ;
  logic [1:0]       rateQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLast;
  logic             ctrlWrite;
  logic             tickNow;

  assign ctrlWrite = wrEn && (wrAddr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ      <= 1'b0;
      rateQ     <= 2'b00;
      cmpShadow <= '0;
      selShadow <= '0;
    end else if (wrEn) begin
      if (ctrlWrite) begin
        runQ  <= wrData[0];
        rateQ <= wrData[2:1];
      end
      for (int i = 0; i < COILS; i++) begin
        if (wrAddr == ADDR_W'(1 + i))
          cmpShadow[i] <= wrData[CNT_W-1:0];
        if (wrAddr == ADDR_W'(1 + COILS + i))
          selShadow[i] <= wrData[1:0];
      end
    end
  end

  always_comb begin
    case (rateQ)
      2'b00:   divLast = PRE_W'(RATE0_DIV - 1);
      2'b01:   divLast = PRE_W'(RATE1_DIV - 1);
      2'b10:   divLast = PRE_W'(RATE2_DIV - 1);
      default: divLast = PRE_W'(RATE3_DIV - 1);
    endcase
  end

  assign tickNow = runQ && (preCnt >= divLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      preCnt <= '0;
    else if (!runQ || tickNow || ctrlWrite)
      preCnt <= '0;
    else
      preCnt <= preCnt + 1'b1;
  end

  assign strobe.run  = runQ;
  assign strobe.tick = tickNow;

  // R7: with any divided rate, two count steps are never back to back
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tickNow && rateQ != 2'b00 && !ctrlWrite) |=> !tickNow);

  // R1: reset leaves the block switched off
  a_r1_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !runQ);

endmodule

// File: rtl/stepper_pwm_datapath.sv
module stepper_pwm_datapath
  import stepper_pwm_pkg::*;
#(
  parameter int COILS = 2,
  parameter int CNT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pwmStrobe_t                    strobe,
  input  logic [COILS-1:0][CNT_W-1:0]   cmpShadow,
  input  logic [COILS-1:0][1:0]         selShadow,
  input  logic [2*COILS-1:0]            portBits,
  output logic [2*COILS-1:0]            coilOut
);

  localparam int OUT_W = 2 * COILS;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]             cnt;
  logic [COILS-1:0][CNT_W-1:0]  cmpWork;
  logic [COILS-1:0][1:0]        selWork;
  logic [OUT_W-1:0]             pwmNext;
  logic [OUT_W-1:0]             outQ;
  logic                         wrap;

  assign wrap = strobe.run && strobe.tick && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmpWork <= '0;
      selWork <= '0;
      outQ    <= '0;
    end else if (!strobe.run) begin
      cnt     <= '0;
      cmpWork <= cmpShadow;
      selWork <= selShadow;
      outQ    <= portBits;
    end else begin
      if (strobe.tick) cnt <= cnt + 1'b1;
      if (wrap) begin
        cmpWork <= cmpShadow;
        selWork <= selShadow;
      end
      outQ <= pwmNext;
    end
  end

  for (genvar i = 0; i < COILS; i++) begin : g_coil
    logic       active;
    logic [1:0] pairNext;

    assign active = cnt < cmpWork[i];

    always_comb begin
      case (coilSel_e'(selWork[i]))
        SEL_PLUS:  pairNext = {1'b0, active};
        SEL_MINUS: pairNext = {active, 1'b0};
        SEL_BRAKE: pairNext = 2'b11;
        default:   pairNext = 2'b00;
      endcase
    end

    assign pwmNext[2*i +: 2] = pairNext;

    // R9: a pair is doubly high only under the brake code
    a_r9_no_dual_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.run && selWork[i] != SEL_BRAKE) |=> !(outQ[2*i] && outQ[2*i+1]));
  end

  assign coilOut = outQ;

  // R2: switched off, the outputs follow the port bits one clock later
  a_r2_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.run |=> (outQ == $past(portBits)));

  // R3: each count step advances the shared counter by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.run && strobe.tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R8: working values stay put between wraps
  a_r8_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.run && !wrap) |=> ($stable(cmpWork) && $stable(selWork)));

endmodule

// File: rtl/stepper_pwm_drive.sv
module stepper_pwm_drive
  import stepper_pwm_pkg::*;
#(
  parameter int COILS     = 2,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int RATE0_DIV = 1,
  parameter int RATE1_DIV = 2,
  parameter int RATE2_DIV = 4,
  parameter int RATE3_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        portBits,
  output logic [3:0]        coilOut
);

  localparam int OUT_W = 2 * COILS;

  pwmStrobe_t                  strobe;
  logic [COILS-1:0][CNT_W-1:0] cmpShadow;
  logic [COILS-1:0][1:0]       selShadow;
  logic [OUT_W-1:0]            dpOut;

  stepper_pwm_ctrl #(
    .COILS(COILS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RATE0_DIV(RATE0_DIV), .RATE1_DIV(RATE1_DIV),
    .RATE2_DIV(RATE2_DIV), .RATE3_DIV(RATE3_DIV)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .cmpShadow(cmpShadow), .selShadow(selShadow)
  );

  stepper_pwm_datapath #(
    .COILS(COILS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cmpShadow(cmpShadow), .selShadow(selShadow),
    .portBits(OUT_W'(portBits)), .coilOut(dpOut)
  );

  assign coilOut = 4'(dpOut);

endmodule

// File: tb/stepper_pwm_drive_tb.sv
module stepper_pwm_drive_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] portBits = '0;
  logic [3:0] coilOut;

  int nChecks = 0;
  int nErr = 0;

  typedef struct {
    int hi[4];
    int dual[2];
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  stepper_pwm_drive u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .portBits(portBits), .coilOut(coilOut)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pushExp(input int h0, input int h1, input int h2, input int h3,
                         input int d0, input int d1);
    expItem_t e;
    e.hi[0] = h0; e.hi[1] = h1; e.hi[2] = h2; e.hi[3] = h3;
    e.dual[0] = d0; e.dual[1] = d1;
    expQ.push_back(e);
  endtask

  // Monitor: measures windows of 256*d samples and compares against the queue
  task automatic measure(input int nWin, input int d, input string req);
    for (int w = 0; w < nWin; w++) begin
      int hi[4];
      int dual[2];
      bit seenLow[4];
      int prefixBad;
      expItem_t e;
      prefixBad = 0;
      for (int k = 0; k < 4; k++) begin hi[k] = 0; seenLow[k] = 0; end
      for (int k = 0; k < 2; k++) dual[k] = 0;
      for (int s = 0; s < 256 * d; s++) begin
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          if (coilOut[k]) begin
            hi[k]++;
            if (seenLow[k]) prefixBad++;
          end else seenLow[k] = 1'b1;
        end
        for (int c = 0; c < 2; c++)
          if (coilOut[2*c] && coilOut[2*c+1]) dual[c]++;
      end
      e = expQ.pop_front();
      for (int k = 0; k < 4; k++)
        checkEq(req, $sformatf("window %0d high count out%0d", w, k), hi[k], e.hi[k]);
      checkEq("R9", $sformatf("window %0d coil A both-high", w), dual[0], e.dual[0]);
      checkEq("R9", $sformatf("window %0d coil B both-high", w), dual[1], e.dual[1]);
      checkEq("R3", $sformatf("window %0d high time not a leading stretch", w), prefixBad, 0);
    end
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    portBits = 4'b1111;
    @(negedge clk);
    checkEq("R1", "outputs during reset", int'(coilOut), 0);
    rst_n = 1'b1;

    // R2: port fallback while switched off
    portBits = 4'b1010;
    repeat (2) @(negedge clk);
    checkEq("R2", "fallback 1010", int'(coilOut), 4'b1010);
    portBits = 4'b0101;
    @(negedge clk);
    checkEq("R2", "fallback one clock later", int'(coilOut), 4'b0101);

    // Test A: rate 00, plus on A, minus on B, then mid-period update (R5, R8, R10)
    writeReg(3'd1, 8'd64);
    writeReg(3'd2, 8'd200);
    writeReg(3'd3, 8'b01);
    writeReg(3'd4, 8'b10);
    pushExp(64, 0, 0, 200, 0, 0);        // R8: old values for the running window
    pushExp(0, 10, 256, 256, 0, 256);    // R5 minus on A, R6 brake on B
    writeReg(3'd0, 8'b001);
    fork
      measure(2, 1, "R5/R8");
      begin
        repeat (100) @(negedge clk);
        writeReg(3'd1, 8'd10);
        writeReg(3'd3, 8'b10);
        writeReg(3'd2, 8'd0);
        writeReg(3'd4, 8'b11);
        writeReg(3'd5, 8'hFF);           // R10: unused address, no effect
        writeReg(3'd6, 8'h00);
      end
    join

    // Test B: rate 01, duty 255 and duty 1 (R4, R7)
    writeReg(3'd0, 8'b000);
    writeReg(3'd1, 8'd255);
    writeReg(3'd2, 8'd1);
    writeReg(3'd3, 8'b01);
    writeReg(3'd4, 8'b01);
    pushExp(510, 0, 2, 0, 0, 0);
    writeReg(3'd0, 8'b011);
    measure(1, 2, "R4/R7");

    // Test C: rate 10, duty 0 and half duty on minus (R4, R7)
    writeReg(3'd0, 8'b000);
    writeReg(3'd1, 8'd0);
    writeReg(3'd2, 8'd128);
    writeReg(3'd4, 8'b10);
    pushExp(0, 0, 0, 512, 0, 0);
    writeReg(3'd0, 8'b101);
    measure(1, 4, "R4/R7");

    // Test D: rate 11, minus on A, brake on B (R6, R7)
    writeReg(3'd0, 8'b000);
    writeReg(3'd1, 8'd3);
    writeReg(3'd3, 8'b10);
    writeReg(3'd2, 8'd255);
    writeReg(3'd4, 8'b11);
    pushExp(0, 48, 4096, 4096, 0, 4096);
    writeReg(3'd0, 8'b111);
    measure(1, 16, "R6/R7");

    // R2: switched off again, outputs return to the port bits
    portBits = 4'b0110;
    writeReg(3'd0, 8'b000);
    repeat (2) @(negedge clk);
    checkEq("R2", "fallback after disable", int'(coilOut), 4'b0110);

    // R5: steering code 00 holds both outputs low
    writeReg(3'd3, 8'b00);
    writeReg(3'd4, 8'b00);
    writeReg(3'd1, 8'd200);
    pushExp(0, 0, 0, 0, 0, 0);
    writeReg(3'd0, 8'b001);
    measure(1, 1, "R5");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule